// File: doc/BRIEF.md
# Panel Power Sequencer

This block walks a serial command writer through fixed lists of panel register writes. Four lists are held in an internal table: power-up, display-on, display-off and power-down. Each list has its own request input. A table entry holds a register address, a payload length of 0, 1 or 2 bytes, a 16-bit value and an optional wait in milliseconds. The wait is timed with a tick counter derived from the `CLK_HZ` parameter.

The writer sees one write at a time through a request/acknowledge handshake. With the acknowledge it returns an error flag. The power-up list aborts on its first failed write: no further writes are issued, and the list still finishes and reports the failure. The other lists run to the end whatever the writer returns.

The host starts a list with a one-cycle request. It watches `busy_o`, takes the one-cycle `done_o` as completion, and reads the sticky `err_o`.

Top module: `panel_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `wr_req_o` are all 0.
- R2: Power-up opens with three command-only writes (length 0) of address 0x00. After each of them comes a wait of at least 1 ms and at most 2 ms. The wait is measured from the acknowledge to the next `wr_req_o`.
- R3: In power-up, write 4 is address 0xB0 with 0x17 (length 1) and write 7 is 0xB0 with 0x16 (length 1). Write 8 is 0xB8 with 0xFFF9 (length 2), followed at once by write 9, the command-only 0x11.
- R4: A clean power-up issues exactly 43 writes. Among them, 0xBD is written with 0x04, and the last write is 0xD5 with 0x0E.
- R5: `busy_o` is 1 from the cycle after an accepted request until the list ends. The end is marked by a single `done_o` cycle, after which `busy_o` returns to 0.
- R6: In power-up, if write k (counting from 0) is acknowledged with an error, then exactly k+1 writes are issued. `done_o` still pulses and `err_o` reads 1.
- R7: Display-on issues the single command-only write 0x29. Display-off issues the single command-only write 0x28.
- R8: Power-down issues three writes in this order: 0xB8 with 0x8002 (length 2), command-only 0x10, and 0xB0 with 0x00 (length 1). All three are issued even if earlier ones fail, and `err_o` reflects any failure.
- R9: Any request that arrives while `busy_o` is 1 is ignored.
- R10: `err_o` is cleared when a list starts. It then holds its value until the next list starts.
- R11: When several requests arrive in the same idle cycle, the winner is chosen in this order: power-up, then display-on, then display-off, then power-down.
- R12: `wr_req_o` stays high, with `wr_addr_o`, `wr_len_o` and `wr_data_o` stable, until `wr_ack_i`. The length code is 0, 1 or 2. A one-byte payload is carried in `wr_data_o[7:0]`, with the upper byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_req_i | input | 1 | Start power-up list |
| disp_on_req_i | input | 1 | Start display-on list |
| disp_off_req_i | input | 1 | Start display-off list |
| pwr_dn_req_i | input | 1 | Start power-down list |
| wr_req_o | output | 1 | Write request to command writer |
| wr_addr_o | output | 8 | Register address / command byte |
| wr_len_o | output | 2 | Payload length in bytes (0, 1, 2) |
| wr_data_o | output | 16 | Payload value |
| wr_ack_i | input | 1 | Writer finished current write |
| wr_err_i | input | 1 | Writer error, valid with `wr_ack_i` |
| busy_o | output | 1 | A list is running |
| done_o | output | 1 | One-cycle list completion |
| err_o | output | 1 | Sticky error of the last list |

## Verification
The bench builds the block with `CLK_HZ` set to 50_000, so one millisecond is 50 cycles. That makes it cheap to measure the gaps after the three opening commands against both bounds and to run the full 43-write power-up list many times. A writer model acknowledges after a random latency and fails a chosen write. This places aborts at arbitrary points in power-up and failures throughout power-down. It also covers requests that arrive mid-list or on the same cycle.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int ADDR_W = 8;
  localparam int VAL_W  = 16;
  localparam int LEN_W  = 2;
  localparam int MS_W   = 2;
  localparam int LIST_N = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [VAL_W-1:0]  val;
    logic [MS_W-1:0]   wait_ms;
  } step_t;

  // index order is request priority
  typedef enum logic [1:0] {
    L_PWR_UP   = 2'd0,
    L_DISP_ON  = 2'd1,
    L_DISP_OFF = 2'd2,
    L_PWR_DN   = 2'd3
  } list_e;

  typedef enum logic [1:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_FINISH
  } state_e;

  localparam int PU_LEN   = 43;
  localparam int ON_LEN   = 1;
  localparam int OFF_LEN  = 1;
  localparam int PD_LEN   = 3;
  localparam int PU_BASE  = 0;
  localparam int ON_BASE  = PU_BASE + PU_LEN;
  localparam int OFF_BASE = ON_BASE + ON_LEN;
  localparam int PD_BASE  = OFF_BASE + OFF_LEN;
  localparam int STEP_N   = PD_BASE + PD_LEN;
  localparam int IDX_W    = $clog2(STEP_N);

  function automatic logic [IDX_W-1:0] list_first(list_e l);
    case (l)
      L_PWR_UP:   return IDX_W'(PU_BASE);
      L_DISP_ON:  return IDX_W'(ON_BASE);
      L_DISP_OFF: return IDX_W'(OFF_BASE);
      default:    return IDX_W'(PD_BASE);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] list_last(list_e l);
    case (l)
      L_PWR_UP:   return IDX_W'(PU_BASE + PU_LEN - 1);
      L_DISP_ON:  return IDX_W'(ON_BASE + ON_LEN - 1);
      L_DISP_OFF: return IDX_W'(OFF_BASE + OFF_LEN - 1);
      default:    return IDX_W'(PD_BASE + PD_LEN - 1);
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_arb.sv
module panel_seq_arb
  import panel_seq_pkg::*;
(
  input  logic [LIST_N-1:0] req_i,
  output logic              any_o,
  output list_e             sel_o
);
  always_comb begin
    sel_o = L_PWR_UP;
    for (int i = LIST_N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = list_e'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o
);
  function automatic step_t mk(logic [7:0] a, logic [1:0] n, logic [15:0] v, logic [1:0] w);
    step_t s;
    s.addr = a; s.len = n; s.val = v; s.wait_ms = w;
    return s;
  endfunction

  function automatic step_t step_at(logic [IDX_W-1:0] i);
    case (i)
      // power-up: wake pulses, then rails and sleep exit
      6'd0:  return mk(8'h00, 2'd0, 16'h0000, 2'd1);
      6'd1:  return mk(8'h00, 2'd0, 16'h0000, 2'd1);
      6'd2:  return mk(8'h00, 2'd0, 16'h0000, 2'd1);
      6'd3:  return mk(8'hB0, 2'd1, 16'h0017, 2'd0);
      6'd4:  return mk(8'hBC, 2'd1, 16'h0080, 2'd0);
      6'd5:  return mk(8'h3B, 2'd1, 16'h0000, 2'd0);
      6'd6:  return mk(8'hB0, 2'd1, 16'h0016, 2'd0);
      6'd7:  return mk(8'hB8, 2'd2, 16'hFFF9, 2'd0);
      6'd8:  return mk(8'h11, 2'd0, 16'h0000, 2'd0);
      // power-up: register set
      6'd9:  return mk(8'hBA, 2'd1, 16'h0001, 2'd0);
      6'd10: return mk(8'hBB, 2'd1, 16'h0000, 2'd0);
      6'd11: return mk(8'h3A, 2'd1, 16'h0060, 2'd0);
      6'd12: return mk(8'hBF, 2'd1, 16'h0010, 2'd0);
      6'd13: return mk(8'hB1, 2'd1, 16'h0056, 2'd0);
      6'd14: return mk(8'hB2, 2'd1, 16'h0033, 2'd0);
      6'd15: return mk(8'hB3, 2'd1, 16'h0011, 2'd0);
      6'd16: return mk(8'hB3, 2'd1, 16'h0011, 2'd0);
      6'd17: return mk(8'hB4, 2'd1, 16'h0002, 2'd0);
      6'd18: return mk(8'hB5, 2'd1, 16'h002B, 2'd0);
      6'd19: return mk(8'hB6, 2'd1, 16'h0040, 2'd0);
      6'd20: return mk(8'hB7, 2'd1, 16'h0003, 2'd0);
      6'd21: return mk(8'hB9, 2'd1, 16'h0004, 2'd0);
      6'd22: return mk(8'hBD, 2'd1, 16'h0004, 2'd0); // not default, flicker fix
      6'd23: return mk(8'hBE, 2'd1, 16'h0000, 2'd0);
      6'd24: return mk(8'hC0, 2'd1, 16'h0011, 2'd0);
      6'd25: return mk(8'hC1, 2'd1, 16'h0011, 2'd0);
      6'd26: return mk(8'hC2, 2'd1, 16'h0011, 2'd0);
      6'd27: return mk(8'hC3, 2'd2, 16'h2040, 2'd0);
      6'd28: return mk(8'hC4, 2'd2, 16'h60C0, 2'd0);
      6'd29: return mk(8'hC5, 2'd2, 16'h1020, 2'd0);
      6'd30: return mk(8'hC6, 2'd2, 16'h60C0, 2'd0);
      6'd31: return mk(8'hC7, 2'd2, 16'h5533, 2'd0);
      6'd32: return mk(8'hC8, 2'd1, 16'h0000, 2'd0);
      6'd33: return mk(8'hC9, 2'd1, 16'h0000, 2'd0);
      6'd34: return mk(8'hCA, 2'd1, 16'h0000, 2'd0);
      6'd35: return mk(8'hEC, 2'd2, 16'h01F0, 2'd0);
      6'd36: return mk(8'hCF, 2'd1, 16'h0002, 2'd0);
      6'd37: return mk(8'hD0, 2'd2, 16'h0804, 2'd0);
      6'd38: return mk(8'hD1, 2'd1, 16'h0001, 2'd0);
      6'd39: return mk(8'hD2, 2'd2, 16'h0000, 2'd0);
      6'd40: return mk(8'hD3, 2'd2, 16'h0D0E, 2'd0);
      6'd41: return mk(8'hD4, 2'd2, 16'h11A4, 2'd0);
      6'd42: return mk(8'hD5, 2'd1, 16'h000E, 2'd0);
      // display on / off
      6'd43: return mk(8'h29, 2'd0, 16'h0000, 2'd0);
      6'd44: return mk(8'h28, 2'd0, 16'h0000, 2'd0);
      // power-down
      6'd45: return mk(8'hB8, 2'd2, 16'h8002, 2'd0);
      6'd46: return mk(8'h10, 2'd0, 16'h0000, 2'd0);
      6'd47: return mk(8'hB0, 2'd1, 16'h0000, 2'd0);
      default: return '0;
    endcase
  endfunction

  always_comb step_o = step_at(idx_i);
endmodule

// File: rtl/panel_seq_delay.sv
module panel_seq_delay #(
  parameter int unsigned TICKS = 100_000,
  parameter int          MW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] ms_i,
  output logic          fin_o
);
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [TW-1:0] tick_q;
  logic [MW-1:0] ms_q;
  logic          run_q;

  assign fin_o = run_q && (tick_q == '0) && (ms_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      ms_q   <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      tick_q <= TW'(TICKS - 1);
      ms_q   <= ms_i - MW'(1);
    end else if (run_q) begin
      if (tick_q == '0) begin
        if (ms_q == '0) begin
          run_q <= 1'b0;
        end else begin
          ms_q   <= ms_q - MW'(1);
          tick_q <= TW'(TICKS - 1);
        end
      end else begin
        tick_q <= tick_q - TW'(1);
      end
    end
  end
endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import panel_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_up_req_i,
  input  logic              disp_on_req_i,
  input  logic              disp_off_req_i,
  input  logic              pwr_dn_req_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [VAL_W-1:0]  wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned TICKS_PER_MS = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;

  state_e           state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             abort_q, err_q;
  logic             any_req, dly_start, dly_fin, fail_stop;
  list_e            sel;
  step_t            step;

  panel_seq_arb u_arb (
    .req_i ({pwr_dn_req_i, disp_off_req_i, disp_on_req_i, pwr_up_req_i}),
    .any_o (any_req),
    .sel_o (sel)
  );

  panel_seq_rom u_rom (
    .idx_i  (idx_q),
    .step_o (step)
  );

  panel_seq_delay #(.TICKS(TICKS_PER_MS), .MW(MS_W)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dly_start),
    .ms_i    (step.wait_ms),
    .fin_o   (dly_fin)
  );

  assign fail_stop = wr_ack_i && wr_err_i && abort_q;
  assign dly_start = (state_q == S_ISSUE) && wr_ack_i && !fail_stop && (step.wait_ms != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (any_req) begin
          idx_q   <= list_first(sel);
          last_q  <= list_last(sel);
          abort_q <= (sel == L_PWR_UP);
          err_q   <= 1'b0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (wr_ack_i) begin
          if (wr_err_i) err_q <= 1'b1;
          if (fail_stop)                 state_q <= S_FINISH;
          else if (step.wait_ms != '0)   state_q <= S_WAIT;
          else if (idx_q == last_q)      state_q <= S_FINISH;
          else                           idx_q   <= idx_q + IDX_W'(1);
        end
        S_WAIT: if (dly_fin) begin
          if (idx_q == last_q) begin
            state_q <= S_FINISH;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_req_o  = (state_q == S_ISSUE);
  assign wr_addr_o = step.addr;
  assign wr_len_o  = step.len;
  assign wr_data_o = step.val;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_FINISH);
  assign err_o     = err_q;
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwr_up_req_i,
  input logic        disp_on_req_i,
  input logic        disp_off_req_i,
  input logic        pwr_dn_req_i,
  input logic        wr_req_o,
  input logic [7:0]  wr_addr_o,
  input logic [1:0]  wr_len_o,
  input logic [15:0] wr_data_o,
  input logic        wr_ack_i,
  input logic        wr_err_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  logic any_req;
  assign any_req = pwr_up_req_i | disp_on_req_i | disp_off_req_i | pwr_dn_req_i;

  assert_req_in_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> busy_o);

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_len_o) && $stable(wr_data_o));

  assert_len_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_len_o != 2'd3);

  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && any_req |=> busy_o);

  assert_done_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  assert_err_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i && wr_err_i |=> err_o);

  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !err_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o || $rose(busy_o));
endmodule

bind panel_seq panel_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pwr_up_req_i   (pwr_up_req_i),
  .disp_on_req_i  (disp_on_req_i),
  .disp_off_req_i (disp_off_req_i),
  .pwr_dn_req_i   (pwr_dn_req_i),
  .wr_req_o       (wr_req_o),
  .wr_addr_o      (wr_addr_o),
  .wr_len_o       (wr_len_o),
  .wr_data_o      (wr_data_o),
  .wr_ack_i       (wr_ack_i),
  .wr_err_i       (wr_err_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/panel_seq_bench.sv
module panel_seq_bench;
  localparam int unsigned CLK_HZ = 50_000;
  localparam int T = CLK_HZ / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic pu = 0, on = 0, off = 0, pd = 0;
  logic wr_req, wr_ack = 0, wr_err = 0;
  logic [7:0] wr_addr; logic [1:0] wr_len; logic [15:0] wr_data;
  logic busy, done, err;

  panel_seq #(.CLK_HZ(CLK_HZ)) u_panel_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .pwr_up_req_i(pu), .disp_on_req_i(on), .disp_off_req_i(off), .pwr_dn_req_i(pd),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_len_o(wr_len), .wr_data_o(wr_data),
    .wr_ack_i(wr_ack), .wr_err_i(wr_err),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // writer model log
  logic [7:0] la [64]; logic [1:0] ll [64]; logic [15:0] ld [64];
  int st [64]; int ak [64];
  int wn = 0, fail_at = -1, lat = 0;
  bit fresh = 1;
  bit err_start, err_done;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int exp_len(input int l);
    case (l) 0: return 43; 1: return 1; 2: return 1; default: return 3; endcase
  endfunction
  function automatic int exp_cnt(input int l, input int fa);
    if (l == 0 && fa >= 0 && fa < 43) return fa + 1;
    return exp_len(l);
  endfunction
  function automatic bit exp_err(input int l, input int fa);
    return fa >= 0 && fa < exp_len(l);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        wr_ack = 0; wr_err = 0;
      end else if (wr_ack) begin
        wr_ack = 0; wr_err = 0; lat = $urandom_range(0, 3); fresh = 1;
      end else if (wr_req && wn < 64) begin
        if (fresh) begin st[wn] = cyc; fresh = 0; end
        if (lat == 0) begin
          wr_ack = 1; wr_err = (wn == fail_at);
          la[wn] = wr_addr; ll[wn] = wr_len; ld[wn] = wr_data; ak[wn] = cyc;
          wn++;
        end else lat--;
      end
    end
  end

  // reqv bit0 power-up, bit1 on, bit2 off, bit3 power-down
  task automatic run(input logic [3:0] reqv, input int fa, input bit intrude);
    int k = 0;
    bit seen = 0;
    wn = 0; fail_at = fa;
    @(negedge clk);
    {pd, off, on, pu} = reqv;
    @(negedge clk);
    {pd, off, on, pu} = 4'b0;
    chk(busy == 1'b1, "R5 busy after request", busy, 1);
    err_start = err;
    while (!seen && k < 20000) begin
      @(negedge clk);
      k++;
      on = (intrude && k == 30);
      if (done) begin seen = 1; err_done = err; end
    end
    on = 0;
    chk(seen, "R5 done pulse", seen, 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R5 idle after done", {busy, done}, 0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int found;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && wr_req == 0, "R1 reset state",
        {busy, done, err, wr_req}, 0);

    // clean power-up
    run(4'b0001, -1, 0);
    chk(wn == 43, "R4 power-up count", wn, 43);
    for (int i = 0; i < 3; i++) begin
      chk(la[i] == 8'h00 && ll[i] == 2'd0, "R2 wake command", {la[i], ll[i]}, 0);
      chk(st[i+1] - ak[i] >= T && st[i+1] - ak[i] <= 2 * T, "R2 wake gap", st[i+1] - ak[i], T);
    end
    chk(la[3] == 8'hB0 && ld[3] == 16'h0017 && ll[3] == 2'd1, "R3 standby exit", ld[3], 16'h17);
    chk(la[6] == 8'hB0 && ld[6] == 16'h0016 && ll[6] == 2'd1, "R3 rails on", ld[6], 16'h16);
    chk(la[7] == 8'hB8 && ld[7] == 16'hFFF9 && ll[7] == 2'd2, "R3 output control R12", ld[7], 16'hFFF9);
    chk(la[8] == 8'h11 && ll[8] == 2'd0, "R3 sleep out", la[8], 8'h11);
    found = 0;
    for (int i = 0; i < 43; i++) if (la[i] == 8'hBD && ld[i] == 16'h0004) found++;
    chk(found == 1, "R4 slew register", found, 1);
    chk(la[42] == 8'hD5 && ld[42] == 16'h000E, "R4 last write", la[42], 8'hD5);
    chk(err_done == 0, "R5 no error", err_done, 0);

    // display on / off
    run(4'b0010, -1, 0);
    chk(wn == 1 && la[0] == 8'h29 && ll[0] == 2'd0, "R7 display on", la[0], 8'h29);
    run(4'b0100, -1, 0);
    chk(wn == 1 && la[0] == 8'h28 && ll[0] == 2'd0, "R7 display off", la[0], 8'h28);

    // power-down clean and with early failure
    run(4'b1000, -1, 0);
    chk(wn == 3, "R8 power-down count", wn, 3);
    chk(la[0] == 8'hB8 && ld[0] == 16'h8002 && ll[0] == 2'd2, "R8 output off", ld[0], 16'h8002);
    chk(la[1] == 8'h10 && ll[1] == 2'd0, "R8 sleep in", la[1], 8'h10);
    chk(la[2] == 8'hB0 && ld[2] == 16'h0000 && ll[2] == 2'd1, "R8 power off", la[2], 8'hB0);
    run(4'b1000, 0, 0);
    chk(wn == 3, "R8 continue after error", wn, 3);
    chk(err_done == 1, "R8 error flag", err_done, 1);

    // power-up abort
    run(4'b0001, 5, 0);
    chk(wn == 6, "R6 abort count", wn, 6);
    chk(err_done == 1, "R6 error flag", err_done, 1);
    chk(err == 1, "R10 error held while idle", err, 1);
    run(4'b0010, -1, 0);
    chk(err_start == 0, "R10 cleared at start", err_start, 0);

    // request while busy
    run(4'b0001, -1, 1);
    found = 0;
    for (int i = 0; i < wn; i++) if (la[i] == 8'h29) found++;
    chk(wn == 43 && found == 0, "R9 request ignored", wn, 43);

    // simultaneous requests
    run(4'b1001, -1, 0);
    chk(wn == 43 && la[0] == 8'h00, "R11 power-up wins", wn, 43);
    run(4'b0110, -1, 0);
    chk(wn == 1 && la[0] == 8'h29, "R11 display-on wins", la[0], 8'h29);

    // random lists and failure points
    for (int it = 0; it < 12; it++) begin
      int l = $urandom_range(0, 3);
      int fa = ($urandom_range(0, 1) == 1) ? $urandom_range(0, exp_len(l) - 1) : -1;
      run(4'b0001 << l, fa, 0);
      chk(wn == exp_cnt(l, fa), "R6 R8 random count", wn, exp_cnt(l, fa));
      chk(err_done == exp_err(l, fa), "R6 R8 random error", err_done, exp_err(l, fa));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule